// File: doc/BRIEF.md
# Bus ID-Assignment Selection Responder

This block sits on a parallel SCSI-style bus and takes part in the selection phase of the ID-assignment protocol. It watches three synchronized bus levels (SEL, MSG and BSY) and accepts a selection once SEL and MSG have both been true, with BSY false, for a programmable run of consecutive cycles. The I/O line and the data lines are not examined at all. The data lines are already released before BSY falls, and I/O plays no part in this phase. The block never drives I/O.

A role input decides whether the block answers. A device that is a target still waiting for an ID, or a level-2 initiator, joins the MSG handshake; any other role leaves the block idle. A target drives MSG for a short per-instance delay, and with a delay of zero it never drives MSG. An initiator holds MSG for a fixed response time. After releasing its own MSG drive, the block waits until the wired-OR MSG line has stayed released for a filter run of cycles. It then pulses `selected_o` for one cycle and stays active until SEL goes false.

Top module: `idsel_responder`

## Requirements
- R1: A selection is accepted only after SEL=1, MSG=1 and BSY=0 have been sampled on STABLE_CYC consecutive clock edges. Outputs react on the following edge, and a shorter run of the pattern is ignored.
- R2: `io_oe_o` is 0 in every cycle. Detection depends only on SEL, MSG and BSY.
- R3: `role_i` encoding: 2'b01 is a target with no assigned ID, 2'b10 is a level-2 initiator, and 2'b00 and 2'b11 do not respond. With a non-responding role, `active_o`, `msg_oe_o` and `selected_o` stay 0.
- R4: In the target role with `tgt_delay_i`=N>0, `active_o` and `msg_oe_o` rise on acceptance and `msg_oe_o` stays 1 for exactly N cycles.
- R5: In the target role with `tgt_delay_i`=0, `msg_oe_o` is never asserted, and the block goes straight to waiting for the MSG release.
- R6: In the initiator role, `msg_oe_o` stays 1 for exactly RESP_CYC cycles, whatever `tgt_delay_i` holds.
- R7: Once its own drive is released, the block raises `selected_o` on the edge after the MSG line has been sampled 0 on FILT_CYC consecutive edges. A one-cycle MSG glitch restarts that count.
- R8: `selected_o` is a one-cycle pulse. Afterwards `active_o` stays 1 while SEL is 1 and falls on the edge that samples SEL=0. No second pulse occurs while SEL stays 1.
- R9: If SEL is sampled 0 before the pulse, the block drops `msg_oe_o` and `active_o` on that edge and returns to idle with no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 1 | Synchronized SEL level (1 = asserted) |
| msg_i | input | 1 | Synchronized wired-OR MSG level, including this block's own drive |
| bsy_i | input | 1 | Synchronized BSY level |
| role_i | input | 2 | Response role (see R3) |
| tgt_delay_i | input | DLY_W | Target-role MSG hold length in cycles; 0 means never drive |
| msg_oe_o | output | 1 | Drive enable for MSG |
| io_oe_o | output | 1 | Drive enable for I/O, always 0 |
| active_o | output | 1 | Block is engaged in a selection |
| selected_o | output | 1 | One-cycle pulse when the filtered MSG release is seen |

## Verification
The main function is tried against several patterns. A non-responding role confirms that the pattern alone never wakes the block. A pattern one cycle short of the qualification run confirms that the stability count matters. Target selections are run with a non-zero delay, with the other device releasing MSG well after this block, and with a single-cycle MSG glitch; together these separate the block's own release from the filtered bus release and show that the filter restarts. A zero-delay target and an initiator with a small delay input show that the hold length follows the role. A SEL drop in the middle of the hold shows the abort path. Every cycle is compared against a behavioural model.

// File: rtl/idsel_pkg.sv
package idsel_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DRIVE  = 2'd1,
    ST_SETTLE = 2'd2,
    ST_HOLD   = 2'd3
  } idsel_state_e;

  localparam logic [1:0] ROLE_TGT  = 2'b01;
  localparam logic [1:0] ROLE_INIT = 2'b10;
endpackage

// File: rtl/idsel_qualifier.sv
module idsel_qualifier #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic ok_o
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LEN_C = CW'(LEN);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
    end else if (!lvl_i) begin
      run_q <= '0;
    end else if (run_q != LEN_C) begin
      run_q <= run_q + 1'b1;
    end
  end

  assign ok_o = (run_q == LEN_C);

  // R1
  ok_level_chk: assert property (@(posedge clk) disable iff (rst)
    ok_o |-> $past(lvl_i));
endmodule

// File: rtl/idsel_timer.sv
module idsel_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          last_o
);
  logic [TW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
    end else if (load_i) begin
      left_q <= val_i;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign last_o = (left_q == TW'(1));

  // R4
  last_count_chk: assert property (@(posedge clk) disable iff (rst)
    last_o && !load_i |=> left_q == '0 || $past(load_i));
endmodule

// File: rtl/idsel_responder.sv
module idsel_responder
  import idsel_pkg::*;
#(
  parameter int STABLE_CYC = 4,
  parameter int RESP_CYC   = 20,
  parameter int FILT_CYC   = 3,
  parameter int DLY_W      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_i,
  input  logic             msg_i,
  input  logic             bsy_i,
  input  logic [1:0]       role_i,
  input  logic [DLY_W-1:0] tgt_delay_i,
  output logic             msg_oe_o,
  output logic             io_oe_o,
  output logic             active_o,
  output logic             selected_o
);
  localparam int RW = $clog2(RESP_CYC + 1);
  localparam int TW = (DLY_W > RW) ? DLY_W : RW;

  logic pat_ok, rel_ok, t_last, t_load;
  logic [TW-1:0] t_val;
  logic is_tgt, is_init;
  idsel_state_e st_q;

  assign is_tgt  = (role_i == ROLE_TGT);
  assign is_init = (role_i == ROLE_INIT);

  idsel_qualifier #(.LEN(STABLE_CYC)) u_pat (
    .clk(clk), .rst(rst), .lvl_i(sel_i & msg_i & ~bsy_i), .ok_o(pat_ok));

  idsel_qualifier #(.LEN(FILT_CYC)) u_rel (
    .clk(clk), .rst(rst), .lvl_i(~msg_i), .ok_o(rel_ok));

  assign t_val  = is_init ? TW'(RESP_CYC) : TW'(tgt_delay_i);
  assign t_load = (st_q == ST_IDLE);

  idsel_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst(rst), .load_i(t_load), .val_i(t_val), .last_o(t_last));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      msg_oe_o   <= 1'b0;
      active_o   <= 1'b0;
      selected_o <= 1'b0;
    end else begin
      selected_o <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (pat_ok && (is_tgt || is_init)) begin
            active_o <= 1'b1;
            if (is_init || tgt_delay_i != '0) begin
              msg_oe_o <= 1'b1;
              st_q     <= ST_DRIVE;
            end else begin
              st_q <= ST_SETTLE;
            end
          end
        end
        ST_DRIVE: begin
          if (!sel_i) begin
            msg_oe_o <= 1'b0;
            active_o <= 1'b0;
            st_q     <= ST_IDLE;
          end else if (t_last) begin
            msg_oe_o <= 1'b0;
            st_q     <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (!sel_i) begin
            active_o <= 1'b0;
            st_q     <= ST_IDLE;
          end else if (rel_ok) begin
            selected_o <= 1'b1;
            st_q       <= ST_HOLD;
          end
        end
        default: begin
          if (!sel_i) begin
            active_o <= 1'b0;
            st_q     <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assign io_oe_o = 1'b0;

  // R8
  sel_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    selected_o |=> !selected_o);

  // R1
  drive_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(active_o) |-> $past(pat_ok));

  // R3
  role_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(active_o) |-> $past(is_tgt || is_init));

  // R7
  filtered_release_chk: assert property (@(posedge clk) disable iff (rst)
    selected_o |-> $past(rel_ok) && !msg_oe_o && active_o);

  // R9
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!sel_i) && $past(st_q != ST_IDLE) |-> !msg_oe_o && !selected_o);
endmodule

// File: tb/idsel_responder_tb.sv
module idsel_responder_tb;
  localparam int STB = 4;
  localparam int RSP = 20;
  localparam int FLT = 3;
  localparam int DW  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel = 1'b0, bsy = 1'b0, oth = 1'b0;
  logic [1:0] role = 2'b00;
  logic [DW-1:0] dly = '0;
  logic msg_oe, io_oe, act, selp;
  wire  msg_bus = oth | msg_oe;

  int checks = 0, fails = 0;
  string cur_req = "R3";
  bit finished = 0;

  always #4 clk = ~clk;

  idsel_responder #(.STABLE_CYC(STB), .RESP_CYC(RSP), .FILT_CYC(FLT), .DLY_W(DW)) u_dut (
    .clk(clk), .rst(rst), .sel_i(sel), .msg_i(msg_bus), .bsy_i(bsy),
    .role_i(role), .tgt_delay_i(dly), .msg_oe_o(msg_oe), .io_oe_o(io_oe),
    .active_o(act), .selected_o(selp));

  // behavioural reference: 0 idle, 1 driving, 2 waiting release, 3 holding
  int m_st, m_pat, m_rel, m_left;
  bit m_oe, m_act, m_sel;

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_pat = 0; m_rel = 0; m_left = 0;
      m_oe = 0; m_act = 0; m_sel = 0;
    end else begin
      bit bus, pok, rok, last;
      bus  = oth | m_oe;
      pok  = (m_pat == STB);
      rok  = (m_rel == FLT);
      last = (m_left == 1);
      if (sel && bus && !bsy) begin if (m_pat < STB) m_pat++; end else m_pat = 0;
      if (!bus) begin if (m_rel < FLT) m_rel++; end else m_rel = 0;
      if (m_st == 0) m_left = (role == 2'b10) ? RSP : int'(dly);
      else if (m_left > 0) m_left--;
      m_sel = 0;
      if (m_st == 0) begin
        if (pok && (role == 2'b01 || role == 2'b10)) begin
          m_act = 1;
          if (role == 2'b10 || dly != 0) begin m_oe = 1; m_st = 1; end
          else m_st = 2;
        end
      end else if (!sel) begin
        m_oe = 0; m_act = 0; m_st = 0;
      end else if (m_st == 1) begin
        if (last) begin m_oe = 0; m_st = 2; end
      end else if (m_st == 2) begin
        if (rok) begin m_sel = 1; m_st = 3; end
      end
    end
  end

  task automatic check(input string req, input string what, input logic a, input logic e);
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, a, e, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      check(cur_req, "msg_oe_o", msg_oe, m_oe);
      check(cur_req, "active_o", act, m_act);
      check(cur_req, "selected_o", selp, m_sel);
      check("R2", "io_oe_o", io_oe, 1'b0);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // hold: cycles other device keeps MSG; drop_at >= 0 ends SEL early
  task automatic run_sel(input int hold, input bit glitch, input int drop_at);
    sel = 1; bsy = 1; oth = 1; cyc(2);
    bsy = 0;
    if (drop_at >= 0) begin
      cyc(drop_at); sel = 0; oth = 0; cyc(6); return;
    end
    cyc(hold); oth = 0;
    if (glitch) begin cyc(2); oth = 1; cyc(1); oth = 0; end
    cyc(12); sel = 0; cyc(5);
  endtask

  initial begin
    cyc(3); rst = 0;
    cur_req = "R3"; cyc(2);
    role = 2'b00; run_sel(30, 0, -1);
    role = 2'b11; run_sel(30, 0, -1);
    cur_req = "R1"; role = 2'b01; dly = 3;
    sel = 1; bsy = 1; oth = 1; cyc(2); bsy = 0; cyc(STB - 1); bsy = 1; cyc(4);
    sel = 0; oth = 0; cyc(4);
    run_sel(8, 0, -1);
    cur_req = "R4"; dly = 5; run_sel(30, 0, -1);
    cur_req = "R7"; dly = 2; run_sel(15, 1, -1);
    cur_req = "R5"; dly = 0; run_sel(10, 0, -1);
    cur_req = "R6"; role = 2'b10; dly = 2; run_sel(6, 0, -1);
    run_sel(40, 1, -1);
    cur_req = "R8"; role = 2'b01; dly = 1; run_sel(4, 0, -1);
    cur_req = "R9"; role = 2'b10; run_sel(0, 0, STB + 6);
    role = 2'b01; dly = 0; run_sel(0, 0, STB + 3);
    cur_req = "R2"; dly = 4; run_sel(12, 0, -1);
    cyc(2);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule